// File: doc/BRIEF.md
# Bank Return Stack Controller

This block widens a 16-bit CPU address to 20 bits. It drives the top four address lines with a current bank number, which selects one of sixteen 64 KB banks in a 1 MB space. The bank part of every return address is kept in a private hardware LIFO. That LIFO moves in step with the CPU's own 16-bit return stack. The result is that long calls, returns and interrupts always come back to the full 20-bit location they left.

The CPU decode logic sends single-cycle strobes: long call, return, IRQ entry, NMI entry and return-from-interrupt. A call or an interrupt entry saves the current bank on the LIFO and then switches to a target bank. The target is the pending jump bank for a call, the IRQ bank for IRQ entry and the NMI bank for NMI entry. The switch lands in time for the target fetch or the vector fetch. A return or return-from-interrupt pops the saved bank and drives it while the CPU pulls its 16-bit return address.

When the window-enable input is high, a small memory-mapped port exposes the internal state for reads and writes. The control registers sit at the bottom of the address space and the LIFO entries sit at 0x0100 and up.

Top module: `bank_stack_ctrl`

## Requirements
- R1: After a synchronous reset, the bank output is 0, the stack pointer is 0, both sticky flags are 0 and the read-data output is 0.
- R2: A call strobe pushes the current bank and makes `jump_bank` the bank output on the cycle after the strobe.
- R3: A return strobe pops the most recently pushed bank and drives it on the cycle after the strobe, so banks come back in last-in first-out order.
- R4: An IRQ-entry strobe pushes the current bank and makes `irq_bank` the bank output on the following cycle.
- R5: An NMI-entry strobe pushes the current bank and makes `nmi_bank` the bank output on the following cycle.
- R6: A return-from-interrupt strobe pops and restores a bank in exactly the same way as a return.
- R7: At most one strobe takes effect per cycle. The priority order is NMI entry, then IRQ entry, then return-from-interrupt, then return, then call.
- R8: The LIFO holds 256 entries. A push onto a full LIFO sets the sticky overflow flag and leaves the pointer and the bank unchanged.
- R9: A pop from an empty LIFO sets the sticky underflow flag and leaves the pointer and the bank unchanged.
- R10: Window reads are registered: `bus_rdata` holds the value one cycle after `bus_rd`. The window map is as follows:
  - address 0x0000 returns the bank in bits 3:0;
  - address 0x0001 returns the low 8 bits of the stack pointer;
  - address 0x0002 returns full in bit 2, underflow in bit 1 and overflow in bit 0;
  - address 0x0100+i returns LIFO entry i in bits 3:0;
  - any other address returns 0.
- R11: Window writes take effect on the next cycle. These are the writable locations:
  - address 0x0000 sets the bank;
  - address 0x0001 sets the pointer;
  - address 0x0002 sets overflow and underflow from data bits 0 and 1;
  - address 0x0100+i sets LIFO entry i.
- R12: While `win_en` is low, window reads return 0 and window writes change nothing. A window write in a cycle that carries any strobe is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_call | input | 1 | Long subroutine call strobe |
| ev_ret | input | 1 | Subroutine return strobe |
| ev_irq | input | 1 | IRQ entry strobe |
| ev_nmi | input | 1 | NMI entry strobe |
| ev_rti | input | 1 | Return-from-interrupt strobe |
| jump_bank | input | 4 | Bank targeted by the next call |
| irq_bank | input | 4 | Bank holding the IRQ handler |
| nmi_bank | input | 4 | Bank holding the NMI handler |
| win_en | input | 1 | Register-window enable |
| bus_addr | input | 16 | Window address |
| bus_rd | input | 1 | Window read request |
| bus_wr | input | 1 | Window write request |
| bus_wdata | input | 8 | Window write data |
| bus_rdata | output | 8 | Registered window read data |
| bank_out | output | 4 | Address bits 19 to 16 |

## Verification
A wrong pointer or a corrupted LIFO entry is not visible on `bank_out` at the time it happens. It shows up on the first return that unwinds past the damaged level, and then the wrong bank appears one cycle after that strobe. The bench therefore unwinds every nesting it builds and also reads the pointer, flags and entries through the window, so that the fault is seen within a cycle of its cause. Flag faults are exposed by filling the LIFO to its full 256 entries and by popping it while empty.

// File: rtl/bank_stack_pkg.sv
package bank_stack_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_PUSH, OP_POP} bank_op_e;
  localparam logic [15:0] WIN_BANK  = 16'h0000;
  localparam logic [15:0] WIN_PTR   = 16'h0001;
  localparam logic [15:0] WIN_FLAGS = 16'h0002;
  localparam logic [15:0] WIN_STK   = 16'h0100;
endpackage

// File: rtl/bank_evt_arb.sv
module bank_evt_arb
  import bank_stack_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic              ev_call,
  input  logic              ev_ret,
  input  logic              ev_irq,
  input  logic              ev_nmi,
  input  logic              ev_rti,
  input  logic [BANK_W-1:0] jump_bank,
  input  logic [BANK_W-1:0] irq_bank,
  input  logic [BANK_W-1:0] nmi_bank,
  output bank_op_e          op,
  output logic [BANK_W-1:0] tgt
);
  // fixed priority: nmi, irq, rti, ret, call
  always_comb begin
    op  = OP_IDLE;
    tgt = jump_bank;
    if (ev_nmi) begin
      op  = OP_PUSH;
      tgt = nmi_bank;
    end else if (ev_irq) begin
      op  = OP_PUSH;
      tgt = irq_bank;
    end else if (ev_rti || ev_ret) begin
      op  = OP_POP;
    end else if (ev_call) begin
      op  = OP_PUSH;
      tgt = jump_bank;
    end
  end
endmodule

// File: rtl/bank_lifo.sv
module bank_lifo #(
  parameter int BANK_W = 4,
  parameter int SP_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [BANK_W-1:0] push_data,
  input  logic              mem_we,
  input  logic [SP_W-1:0]   mem_widx,
  input  logic [BANK_W-1:0] mem_wdata,
  input  logic              cnt_we,
  input  logic [SP_W-1:0]   cnt_wdata,
  input  logic              flag_we,
  input  logic [1:0]        flag_wdata,
  input  logic [SP_W-1:0]   rd_idx,
  output logic [BANK_W-1:0] rd_data,
  output logic [BANK_W-1:0] top_data,
  output logic [SP_W:0]     cnt,
  output logic              full,
  output logic              empty,
  output logic              ovf,
  output logic              unf
);
  localparam int DEPTH = 1 << SP_W;
  localparam logic [SP_W:0] CNT_FULL = (SP_W+1)'(DEPTH);

  logic [BANK_W-1:0] mem [DEPTH];
  logic [SP_W-1:0]   wr_ptr, top_ptr;

  assign wr_ptr   = cnt[SP_W-1:0];
  assign top_ptr  = cnt[SP_W-1:0] - 1'b1;
  assign full     = (cnt == CNT_FULL);
  assign empty    = (cnt == '0);
  assign top_data = mem[top_ptr];
  assign rd_data  = mem[rd_idx];

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push && !full)
      mem[wr_ptr] <= push_data;
    else if (mem_we)
      mem[mem_widx] <= mem_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (push) begin
        if (full) ovf <= 1'b1;
        else      cnt <= cnt + 1'b1;
      end else if (pop) begin
        if (empty) unf <= 1'b1;
        else       cnt <= cnt - 1'b1;
      end else begin
        if (cnt_we)  cnt <= {1'b0, cnt_wdata};
        if (flag_we) begin
          ovf <= flag_wdata[0];
          unf <= flag_wdata[1];
        end
      end
    end
  end

  // R8
  push_full_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (ovf && cnt == $past(cnt)));
  // R9
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (unf && cnt == $past(cnt)));
  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> (cnt == $past(cnt) + 1'b1));
  // R3
  pop_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !empty) |=> (cnt == $past(cnt) - 1'b1));
  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_FULL);
endmodule

// File: rtl/bank_win_mux.sv
module bank_win_mux
  import bank_stack_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int SP_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic [15:0]       addr,
  input  logic [BANK_W-1:0] bank,
  input  logic [SP_W:0]     cnt,
  input  logic              full,
  input  logic              ovf,
  input  logic              unf,
  input  logic [BANK_W-1:0] stk_data,
  output logic              in_stk,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << SP_W;
  localparam logic [16:0] STK_END = 17'(WIN_STK) + 17'(DEPTH);

  assign in_stk = (addr >= WIN_STK) && ({1'b0, addr} < STK_END);

  always_comb begin
    rdata = '0;
    if (in_stk)                rdata = DATA_W'(stk_data);
    else if (addr == WIN_BANK) rdata = DATA_W'(bank);
    else if (addr == WIN_PTR)  rdata = DATA_W'(cnt[SP_W-1:0]);
    else if (addr == WIN_FLAGS) rdata = DATA_W'({full, unf, ovf});
  end
endmodule

// File: rtl/bank_stack_ctrl.sv
module bank_stack_ctrl
  import bank_stack_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int SP_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_call,
  input  logic              ev_ret,
  input  logic              ev_irq,
  input  logic              ev_nmi,
  input  logic              ev_rti,
  input  logic [BANK_W-1:0] jump_bank,
  input  logic [BANK_W-1:0] irq_bank,
  input  logic [BANK_W-1:0] nmi_bank,
  input  logic              win_en,
  input  logic [15:0]       bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [BANK_W-1:0] bank_out
);
  bank_op_e          op;
  logic [BANK_W-1:0] tgt, top_data, stk_rd;
  logic [SP_W:0]     cnt;
  logic              full, empty, ovf, unf, in_stk, win_wr;
  logic [DATA_W-1:0] rd_next;

  bank_evt_arb #(.BANK_W(BANK_W)) u_arb (
    .ev_call(ev_call), .ev_ret(ev_ret), .ev_irq(ev_irq), .ev_nmi(ev_nmi),
    .ev_rti(ev_rti), .jump_bank(jump_bank), .irq_bank(irq_bank),
    .nmi_bank(nmi_bank), .op(op), .tgt(tgt)
  );

  assign win_wr = win_en && bus_wr && (op == OP_IDLE);

  bank_lifo #(.BANK_W(BANK_W), .SP_W(SP_W)) u_lifo (
    .clk(clk), .rst(rst),
    .push(op == OP_PUSH), .pop(op == OP_POP), .push_data(bank_out),
    .mem_we(win_wr && in_stk), .mem_widx(bus_addr[SP_W-1:0]),
    .mem_wdata(bus_wdata[BANK_W-1:0]),
    .cnt_we(win_wr && bus_addr == WIN_PTR), .cnt_wdata(bus_wdata[SP_W-1:0]),
    .flag_we(win_wr && bus_addr == WIN_FLAGS), .flag_wdata(bus_wdata[1:0]),
    .rd_idx(bus_addr[SP_W-1:0]), .rd_data(stk_rd), .top_data(top_data),
    .cnt(cnt), .full(full), .empty(empty), .ovf(ovf), .unf(unf)
  );

  bank_win_mux #(.BANK_W(BANK_W), .SP_W(SP_W), .DATA_W(DATA_W)) u_mux (
    .addr(bus_addr), .bank(bank_out), .cnt(cnt), .full(full), .ovf(ovf),
    .unf(unf), .stk_data(stk_rd), .in_stk(in_stk), .rdata(rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_out  <= '0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= (win_en && bus_rd) ? rd_next : '0;
      if (op == OP_PUSH && !full)
        bank_out <= tgt;
      else if (op == OP_POP && !empty)
        bank_out <= top_data;
      else if (win_wr && bus_addr == WIN_BANK)
        bank_out <= bus_wdata[BANK_W-1:0];
    end
  end

  // R5
  nmi_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_nmi && !full) |=> (bank_out == $past(nmi_bank)));
  // R4
  irq_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_irq && !ev_nmi && !full) |=> (bank_out == $past(irq_bank)));
  // R12
  win_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!win_en) |=> (bus_rdata == '0));
  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PUSH && full) |=> $stable(bank_out));
endmodule

// File: tb/bank_stack_ctrl_test.sv
module bank_stack_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic ev_call = 0, ev_ret = 0, ev_irq = 0, ev_nmi = 0, ev_rti = 0;
  logic [3:0] jump_bank = 0, irq_bank = 0, nmi_bank = 0;
  logic win_en = 0, bus_rd = 0, bus_wr = 0;
  logic [15:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [3:0] bank_out;

  int total = 0, bad = 0;
  bit done = 0;

  // requirement model
  int m_cnt = 0;
  logic [3:0] m_bank = 0;
  logic m_ovf = 0, m_unf = 0;
  logic [3:0] m_stk [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_stack_ctrl uut (
    .clk(clk), .rst(rst), .ev_call(ev_call), .ev_ret(ev_ret), .ev_irq(ev_irq),
    .ev_nmi(ev_nmi), .ev_rti(ev_rti), .jump_bank(jump_bank), .irq_bank(irq_bank),
    .nmi_bank(nmi_bank), .win_en(win_en), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bank_out(bank_out)
  );

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic m_push(input logic [3:0] t);
    if (m_cnt == 256) m_ovf = 1;
    else begin m_stk[m_cnt] = m_bank; m_cnt++; m_bank = t; end
  endtask

  task automatic m_pop();
    if (m_cnt == 0) m_unf = 1;
    else begin m_cnt--; m_bank = m_stk[m_cnt]; end
  endtask

  function automatic int exp_rd(input logic [15:0] a);
    if (!win_en) return 0;
    if (a >= 16'h0100 && a < 16'h0200) return int'(m_stk[a - 16'h0100]);
    if (a == 0) return int'(m_bank);
    if (a == 1) return m_cnt % 256;
    if (a == 2) return ((m_cnt == 256) ? 4 : 0) + (m_unf ? 2 : 0) + (m_ovf ? 1 : 0);
    return 0;
  endfunction

  // ev = {nmi, irq, rti, ret, call}; called at a falling edge
  task automatic cyc(input logic [4:0] ev, input logic wr, input logic [15:0] a,
                     input logic [7:0] d, input string tag);
    {ev_nmi, ev_irq, ev_rti, ev_ret, ev_call} = ev;
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    if (ev[4]) m_push(nmi_bank);
    else if (ev[3]) m_push(irq_bank);
    else if (ev[2] || ev[1]) m_pop();
    else if (ev[0]) m_push(jump_bank);
    else if (wr && win_en) begin
      if (a == 0) m_bank = d[3:0];
      else if (a == 1) m_cnt = int'(d);
      else if (a == 2) begin m_ovf = d[0]; m_unf = d[1]; end
      else if (a >= 16'h0100 && a < 16'h0200) m_stk[a - 16'h0100] = d[3:0];
    end
    {ev_nmi, ev_irq, ev_rti, ev_ret, ev_call} = '0;
    bus_wr = 0;
    chk(int'(bank_out), int'(m_bank), tag);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    int e;
    e = exp_rd(a);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    chk(int'(bus_rdata), e, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    win_en = 1;
    // R1 reset state
    chk(int'(bank_out), 0, "R1 bank");
    chk(int'(bus_rdata), 0, "R1 rdata");
    rd(16'h0001, "R1 ptr");
    rd(16'h0002, "R1 flags");

    // R2 nested calls over every bank, then R3 unwind
    for (int j = 0; j < 16; j++) begin
      jump_bank = 4'(15 - j);
      cyc(5'b00001, 0, 0, 0, "R2 call");
    end
    rd(16'h0001, "R10 ptr after calls");
    for (int i = 0; i < 16; i++) rd(16'h0100 + 16'(i), "R10 stack entry");
    for (int j = 0; j < 16; j++) cyc(5'b00010, 0, 0, 0, "R3 ret lifo");

    // R4 R5 R6 interrupt entry sweep
    for (int i = 0; i < 16; i++) begin
      irq_bank = 4'(i); nmi_bank = 4'(i ^ 5);
      cyc(5'b01000, 0, 0, 0, "R4 irq entry");
      cyc(5'b10000, 0, 0, 0, "R5 nmi entry");
      cyc(5'b00100, 0, 0, 0, "R6 rti");
      cyc(5'b00100, 0, 0, 0, "R6 rti");
    end

    // R7 every strobe combination
    jump_bank = 4'd3; irq_bank = 4'd7; nmi_bank = 4'd11;
    for (int c = 0; c < 32; c++) begin
      cyc(5'b00001, 0, 0, 0, "R7 setup");
      cyc(5'(c), 0, 0, 0, "R7 priority");
      rd(16'h0001, "R7 ptr");
      rd(16'h0002, "R7 flags");
      cyc(5'b0, 1, 16'h0002, 8'h00, "R11 flag clear");
    end

    // R11 window writes, R12 ignore cases
    cyc(5'b0, 1, 16'h0000, 8'h0A, "R11 bank write");
    cyc(5'b0, 1, 16'h0001, 8'h02, "R11 ptr write");
    cyc(5'b0, 1, 16'h0101, 8'h06, "R11 stack write");
    cyc(5'b00010, 0, 0, 0, "R11 pop written entry");
    cyc(5'b00001, 1, 16'h0000, 8'h09, "R12 write during event");
    rd(16'h0001, "R12 ptr after event");
    rd(16'h0005, "R10 unmapped");
    win_en = 0;
    cyc(5'b0, 1, 16'h0000, 8'h0C, "R12 write while off");
    rd(16'h0000, "R12 read while off");
    win_en = 1;
    rd(16'h0000, "R12 bank kept");

    // R8 fill to capacity then overflow; R9 drain then underflow
    cyc(5'b0, 1, 16'h0001, 8'h00, "R11 ptr clear");
    for (int i = 0; i < 256; i++) begin
      jump_bank = 4'(i);
      cyc(5'b00001, 0, 0, 0, "R8 fill");
    end
    rd(16'h0002, "R8 full flag");
    cyc(5'b01000, 0, 0, 0, "R8 push when full");
    rd(16'h0002, "R8 overflow flag");
    rd(16'h0001, "R8 ptr kept");
    for (int i = 0; i < 256; i++) cyc(5'b00010, 0, 0, 0, "R8 drain");
    cyc(5'b00100, 0, 0, 0, "R9 pop when empty");
    rd(16'h0002, "R9 underflow flag");
    rd(16'h0001, "R9 ptr kept");

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule